// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block gathers interrupt requests from a group of on-chip sources and turns them into one prioritised request toward a processor. The first four sources are serial channels. The others are general peripheral sources. Software programs the controller through four word registers on a simple write/read port: a configuration word, a pending set, an enable set and an in-service set.

Each cycle the controller ranks every source that is pending and enabled. The ranking uses four software-mapped slots for the serial channels, a choice between grouped and interleaved placement of those slots, and a field that can lift any one source to the top. A request is raised, at the programmed 3-bit level, only when the best candidate outranks every source already in service. This gives fully nested handling inside a single processor level.

An acknowledge strobe latches an 8-bit vector. The vector is formed from a 3-bit software base and a fixed 5-bit code for the winning source, and the winner is marked as in service.

Top module: `vec_nest_intc`

## Requirements
- R1: Register address 0 is a 24-bit configuration word that resets to zero and reads back what was written, except that bits 4:1 always read as zero. `bus_rdata` is registered: in the cycle after `bus_addr` is presented it shows that register as it stood before any write in the same cycle. Addresses 1, 2 and 3 read the pending, enable and in-service sets, zero-extended.
- R2: A rising edge on `src_req[i]` sets pending bit i. Writing a 1 to bit i at address 1 clears that bit. If an edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: At address 2, enable bit i = 1 lets source i compete and 0 blocks it. A blocked source still becomes pending, but it never raises a request. The enable set resets to all zeros.
- R4: Source codes are fixed. Sources 0..3 (serial channels 1..4) use 11110, 11101, 11100 and 11011. Source 4+k uses 26-k. Code 00000 is the error code.
- R5: Priority works as follows. The source whose code equals configuration bits 12:8 ranks first. Next come the serial slots a, b, c, d (bits 17:16, 19:18, 21:20, 23:22), where field value v places channel v+1 in that slot. With bit 0 = 0 the four slots rank above all other sources, which follow in index order. With bit 0 = 1 the order is a, source 4, b, source 5, c, source 6, d, then the remaining sources. A channel mapped to several slots takes the first of them. An unmapped channel ranks just after slot d. Ties are broken by the lower index.
- R6: A request qualifies only when the highest-ranked pending, enabled source outranks every source whose in-service bit is set.
- R7: `irq_level` equals configuration bits 15:13 in the cycle after a request qualifies. It is 000 in the cycle after no request qualifies.
- R8: `iack` is a one-cycle strobe. In the next cycle `vec_valid` is 1 and `vec_out` is {configuration bits 7:5, code of the winner}. If nothing qualifies, the low five bits are 00000. Otherwise `vec_valid` is 0 and `vec_out` holds its value.
- R9: An acknowledge that finds a qualifying winner sets that source's in-service bit. Writing a 1 to bit i at address 3 clears it. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: A configuration write takes effect in the arbitration of the following cycle, and the level output follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Source request lines, edge sensitive |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 config, 1 pending, 2 enable, 3 in-service |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Registered read data |
| iack | input | 1 | Interrupt acknowledge strobe |
| irq_level | output | 3 | Registered request level, 000 when idle |
| vec_valid | output | 1 | Vector valid, one cycle after `iack` |
| vec_out | output | 8 | Acknowledge vector |

## Verification
The hardest state to reach is a nested one. It needs one source already in service while a lower-ranked source and a newly promoted source are both pending, so that the rank comparison against the in-service set decides the outcome. The stimulus builds this state on purpose. It raises a channel and acknowledges it, then raises lower-ranked sources. It then rewrites the top-priority field so that one of the waiting sources outranks the channel in service. The same pending set is then arbitrated under both slot placements, and same-cycle set and clear collisions are driven. A long random phase follows, compared each clock against a queue-based ordering model.

// File: rtl/vni_pkg.sv
package vni_pkg;
  localparam int CFG_W   = 24;
  localparam int LVL_W   = 3;
  localparam int CODE_W  = 5;
  localparam int BASE_W  = 3;
  localparam int VEC_W   = BASE_W + CODE_W;
  localparam int RANK_W  = 8;
  localparam int NUM_CH  = 4;
  localparam int ADDR_W  = 2;
  localparam logic [CFG_W-1:0] CFG_WMASK = 24'hFFFFE1;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PEND = 2'd1;
  localparam logic [ADDR_W-1:0] A_ENA  = 2'd2;
  localparam logic [ADDR_W-1:0] A_ISR  = 2'd3;

  // fixed vector code of a source
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    if (idx < NUM_CH) return CODE_W'(30 - idx);
    return CODE_W'(26 - (idx - NUM_CH));
  endfunction

  // arbitration rank of a source, smaller is stronger
  function automatic logic [RANK_W-1:0] rank_of(input int idx,
                                                input logic [CFG_W-1:0] cfg);
    int slot;
    int k;
    logic [RANK_W-1:0] r;
    if (idx < NUM_CH) begin
      slot = NUM_CH;
      for (int s = NUM_CH - 1; s >= 0; s--)
        if (int'(cfg[16 + 2*s +: 2]) == idx) slot = s;
      r = cfg[0] ? RANK_W'(1 + 2*slot) : RANK_W'(1 + slot);
    end else begin
      k = idx - NUM_CH;
      if (cfg[0]) r = (k < 3) ? RANK_W'(2 + 2*k) : RANK_W'(10 + k);
      else        r = RANK_W'(6 + k);
    end
    if (cfg[12:8] == src_code(idx)) r = '0;
    return r;
  endfunction
endpackage

// File: rtl/vni_regfile.sv
module vni_regfile
  import vni_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CFG_W-1:0]    wdata,
  input  logic [NUM_SRC-1:0]  src_req,
  input  logic [NUM_SRC-1:0]  isr_set,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [NUM_SRC-1:0]  pend_q,
  output logic [NUM_SRC-1:0]  ena_q,
  output logic [NUM_SRC-1:0]  isr_q,
  output logic [CFG_W-1:0]    rdata
);
  logic [NUM_SRC-1:0] src_d;
  logic [NUM_SRC-1:0] pend_clr;
  logic [NUM_SRC-1:0] isr_clr;
  logic [CFG_W-1:0]   rd_mux;

  function automatic logic [CFG_W-1:0] zext(input logic [NUM_SRC-1:0] v);
    logic [CFG_W-1:0] o;
    o = '0;
    o[NUM_SRC-1:0] = v;
    return o;
  endfunction

  always_comb begin
    pend_clr = (wr && addr == A_PEND) ? wdata[NUM_SRC-1:0] : '0;
    isr_clr  = (wr && addr == A_ISR)  ? wdata[NUM_SRC-1:0] : '0;
    case (addr)
      A_CFG:   rd_mux = cfg_q;
      A_PEND:  rd_mux = zext(pend_q);
      A_ENA:   rd_mux = zext(ena_q);
      default: rd_mux = zext(isr_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d  <= '0;
      cfg_q  <= '0;
      pend_q <= '0;
      ena_q  <= '0;
      isr_q  <= '0;
      rdata  <= '0;
    end else begin
      src_d  <= src_req;
      rdata  <= rd_mux;
      pend_q <= (pend_q & ~pend_clr) | (src_req & ~src_d);
      isr_q  <= (isr_q & ~isr_clr) | isr_set;
      if (wr && addr == A_CFG) cfg_q <= wdata & CFG_WMASK;
      if (wr && addr == A_ENA) ena_q <= wdata[NUM_SRC-1:0];
    end
  end
endmodule

// File: rtl/vni_rank.sv
module vni_rank
  import vni_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int KEY_W  = RANK_W + IDX_W
) (
  input  logic [CFG_W-1:0]   cfg,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] ena,
  input  logic [NUM_SRC-1:0] isr,
  output logic               qualify,
  output logic [IDX_W-1:0]   win_idx
);
  logic [KEY_W-1:0] key [NUM_SRC];
  logic [KEY_W-1:0] best_key;
  logic [KEY_W-1:0] isr_key;
  logic             found;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
    assign key[i] = {rank_of(i, cfg), IDX_W'(i)};
  end

  always_comb begin
    best_key = '1;
    isr_key  = '1;
    found    = 1'b0;
    win_idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && ena[i] && key[i] < best_key) begin
        best_key = key[i];
        win_idx  = IDX_W'(i);
        found    = 1'b1;
      end
      if (isr[i] && key[i] < isr_key) isr_key = key[i];
    end
    qualify = found && (best_key < isr_key);
  end
endmodule

// File: rtl/vni_ack.sv
module vni_ack
  import vni_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iack,
  input  logic               qualify,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [LVL_W-1:0]   cfg_lvl,
  input  logic [BASE_W-1:0]  cfg_base,
  output logic [NUM_SRC-1:0] isr_set,
  output logic [LVL_W-1:0]   irq_level,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out
);
  logic [CODE_W-1:0] win_code;

  always_comb begin
    isr_set = '0;
    if (iack && qualify) isr_set[win_idx] = 1'b1;
    win_code = qualify ? src_code(int'(win_idx)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      irq_level <= qualify ? cfg_lvl : '0;
      vec_valid <= iack;
      if (iack) vec_out <= {cfg_base, win_code};
    end
  end
endmodule

// File: rtl/vec_nest_intc.sv
module vec_nest_intc
  import vni_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [23:0]        bus_wdata,
  output logic [23:0]        bus_rdata,
  input  logic               iack,
  output logic [2:0]         irq_level,
  output logic               vec_valid,
  output logic [7:0]         vec_out
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] ena_q;
  logic [NUM_SRC-1:0] isr_q;
  logic [NUM_SRC-1:0] isr_set;
  logic               qualify;
  logic [IDX_W-1:0]   win_idx;

  vni_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .src_req(src_req), .isr_set(isr_set), .cfg_q(cfg_q), .pend_q(pend_q),
    .ena_q(ena_q), .isr_q(isr_q), .rdata(bus_rdata)
  );

  vni_rank #(.NUM_SRC(NUM_SRC)) u_rank (
    .cfg(cfg_q), .pend(pend_q), .ena(ena_q), .isr(isr_q),
    .qualify(qualify), .win_idx(win_idx)
  );

  vni_ack #(.NUM_SRC(NUM_SRC)) u_ack (
    .clk(clk), .rst(rst), .iack(iack), .qualify(qualify), .win_idx(win_idx),
    .cfg_lvl(cfg_q[15:13]), .cfg_base(cfg_q[7:5]), .isr_set(isr_set),
    .irq_level(irq_level), .vec_valid(vec_valid), .vec_out(vec_out)
  );
endmodule

// File: rtl/vni_checker.sv
module vni_checker #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               iack,
  input logic [NUM_SRC-1:0] src_req,
  input logic               qualify,
  input logic [NUM_SRC-1:0] isr_set,
  input logic [NUM_SRC-1:0] isr_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [2:0]         vbase,
  input logic [2:0]         irq_level,
  input logic               vec_valid,
  input logic [7:0]         vec_out
);
  logic [NUM_SRC-1:0] src_prev;
  logic [NUM_SRC-1:0] src_rise;

  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_req;
  end
  assign src_rise = src_req & ~src_prev;

  assert_valid_follows_ack_R8: assert property (@(posedge clk) disable iff (rst)
    iack |=> vec_valid);
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !iack |=> !vec_valid);
  assert_vector_base_R8: assert property (@(posedge clk) disable iff (rst)
    iack |=> vec_out[7:5] == $past(vbase));
  assert_error_code_R8: assert property (@(posedge clk) disable iff (rst)
    (iack && !qualify) |=> vec_out[4:0] == 5'b0);
  assert_level_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !qualify |=> irq_level == 3'b0);
  assert_isr_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_set));
  assert_isr_marked_R9: assert property (@(posedge clk) disable iff (rst)
    (isr_set != '0) |=> (isr_q & $past(isr_set)) == $past(isr_set));
  assert_pend_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (src_rise != '0) |=> (pend_q & $past(src_rise)) == $past(src_rise));
endmodule

bind vec_nest_intc vni_checker #(.NUM_SRC(NUM_SRC)) u_vni_chk (
  .clk(clk), .rst(rst), .iack(iack), .src_req(src_req), .qualify(qualify),
  .isr_set(isr_set), .isr_q(isr_q), .pend_q(pend_q), .vbase(cfg_q[7:5]),
  .irq_level(irq_level), .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/vec_nest_intc_bench.sv
module vec_nest_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int WD_CYCLES = 150000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_req = '0;
  logic            bus_wr = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [23:0]     bus_wdata = '0;
  logic [23:0]     bus_rdata;
  logic            iack = 1'b0;
  logic [2:0]      irq_level;
  logic            vec_valid;
  logic [7:0]      vec_out;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_nest_intc #(.NUM_SRC(NSRC)) u_vec_nest_intc (
    .clk(clk), .rst(rst), .src_req(src_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .iack(iack), .irq_level(irq_level), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // reference model state
  logic [23:0]     m_cfg;
  logic [NSRC-1:0] m_pend, m_ena, m_isr, m_prev;
  logic [2:0]      e_level;
  logic            e_valid;
  logic [7:0]      e_vec;
  logic [23:0]     e_rdata;
  int order[$];
  bit inl[NSRC];

  function automatic int code_of(int i);
    return (i < 4) ? 30 - i : 26 - (i - 4);
  endfunction

  task automatic add(int i);
    if (i < NSRC && !inl[i]) begin
      order.push_back(i);
      inl[i] = 1;
    end
  endtask

  task automatic build_order();
    order.delete();
    for (int i = 0; i < NSRC; i++) inl[i] = 0;
    for (int i = 0; i < NSRC; i++)
      if (code_of(i) == int'(m_cfg[12:8])) add(i);
    for (int s = 0; s < 4; s++) begin
      add(int'(m_cfg[16 + 2*s +: 2]));
      if (m_cfg[0] && s < 3) add(4 + s);
    end
    for (int i = 0; i < NSRC; i++) add(i);
  endtask

  function automatic logic [23:0] rd_model(logic [1:0] a);
    logic [23:0] v;
    v = '0;
    case (a)
      2'd0: v = m_cfg;
      2'd1: v[NSRC-1:0] = m_pend;
      2'd2: v[NSRC-1:0] = m_ena;
      default: v[NSRC-1:0] = m_isr;
    endcase
    return v;
  endfunction

  task automatic model_step();
    int win, wp, ip;
    bit qual;
    logic [NSRC-1:0] clr_p, clr_i, setv;
    if (rst) begin
      m_cfg = '0; m_pend = '0; m_ena = '0; m_isr = '0; m_prev = '0;
      e_level = '0; e_valid = 0; e_vec = '0; e_rdata = '0;
      return;
    end
    build_order();
    win = -1; wp = -1; ip = -1;
    for (int p = 0; p < order.size(); p++) begin
      if (win < 0 && m_pend[order[p]] && m_ena[order[p]]) begin
        win = order[p]; wp = p;
      end
      if (ip < 0 && m_isr[order[p]]) ip = p;
    end
    qual = (win >= 0) && (ip < 0 || wp < ip);
    e_level = qual ? m_cfg[15:13] : 3'd0;
    e_valid = iack;
    if (iack) e_vec = {m_cfg[7:5], qual ? 5'(code_of(win)) : 5'd0};
    e_rdata = rd_model(bus_addr);
    clr_p = (bus_wr && bus_addr == 2'd1) ? bus_wdata[NSRC-1:0] : '0;
    clr_i = (bus_wr && bus_addr == 2'd3) ? bus_wdata[NSRC-1:0] : '0;
    setv = '0;
    if (iack && qual) setv[win] = 1'b1;
    m_pend = (m_pend & ~clr_p) | (src_req & ~m_prev);
    m_isr  = (m_isr & ~clr_i) | setv;
    m_prev = src_req;
    if (bus_wr && bus_addr == 2'd0) m_cfg = bus_wdata & 24'hFFFFE1;
    if (bus_wr && bus_addr == 2'd2) m_ena = bus_wdata[NSRC-1:0];
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R7 level vs model", 32'(irq_level), 32'(e_level));
    check("R8 valid vs model", 32'(vec_valid), 32'(e_valid));
    check("R8 vector vs model", 32'(vec_out), 32'(e_vec));
    check("R1 rdata vs model", 32'(bus_rdata), 32'(e_rdata));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [23:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [23:0] v);
    bus_addr = a;
    tick();
    v = bus_rdata;
  endtask

  task automatic pulse_ack();
    iack = 1'b1;
    tick();
    iack = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    @(negedge clk);
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R7 reset level", 32'(irq_level), 0);
    check("R8 reset valid", 32'(vec_valid), 0);
    rd(2'd0, v); check("R1 reset config", 32'(v), 0);

    wr(2'd0, 24'hE480BE);
    rd(2'd0, v); check("R1 reserved bits read zero", 32'(v), 32'hE480A0);
    wr(2'd2, 24'h0000FF);
    rd(2'd2, v); check("R3 enable readback", 32'(v), 32'hFF);

    src_req = 8'h01; idle(2);
    check("R7 level when qualified", 32'(irq_level), 4);
    pulse_ack();
    check("R8 valid after ack", 32'(vec_valid), 1);
    check("R4 channel 1 vector", 32'(vec_out), 32'hBE);
    idle(1);
    check("R6 level drops while in service", 32'(irq_level), 0);
    rd(2'd3, v); check("R9 in-service bit set", 32'(v), 32'h01);

    src_req = 8'h13; idle(2);
    check("R6 lower ranks held off", 32'(irq_level), 0);
    wr(2'd3, 24'h01); idle(2);
    check("R9 clear restores request", 32'(irq_level), 4);
    wr(2'd1, 24'h01); idle(2);
    pulse_ack();
    check("R5 slot b above other sources", 32'(vec_out), 32'hBD);
    idle(2);
    check("R6 nested hold", 32'(irq_level), 0);
    wr(2'd0, 24'hE49AA0); idle(1);
    check("R10 promotion takes effect", 32'(irq_level), 4);
    pulse_ack();
    check("R5 promoted source wins", 32'(vec_out), 32'hBA);

    wr(2'd1, 24'hFF); wr(2'd3, 24'hFF); src_req = '0;
    wr(2'd2, 24'h00);
    src_req = 8'h20; idle(2);
    check("R3 blocked source no request", 32'(irq_level), 0);
    rd(2'd1, v); check("R3 blocked source still pending", 32'(v), 32'h20);
    wr(2'd2, 24'hFF); idle(2);
    check("R3 enabled source requests", 32'(irq_level), 4);

    wr(2'd1, 24'hFF); src_req = '0; idle(1);
    wr(2'd0, 24'h1B80A1);
    src_req = 8'h21; idle(2);
    pulse_ack();
    check("R5 interleaved order", 32'(vec_out), 32'hB9);
    wr(2'd3, 24'hFF);
    wr(2'd0, 24'h1B80A0); idle(1);
    pulse_ack();
    check("R5 grouped order", 32'(vec_out), 32'hBE);

    wr(2'd1, 24'hFF); wr(2'd3, 24'hFF); idle(1);
    pulse_ack();
    check("R8 error vector", 32'(vec_out), 32'hA0);

    src_req = '0; idle(1);
    src_req = 8'h04;
    wr(2'd1, 24'h04);
    rd(2'd1, v); check("R2 set wins over clear", 32'(v), 32'h04);
    iack = 1'b1;
    wr(2'd3, 24'h04);
    iack = 1'b0;
    check("R4 channel 3 code", 32'(vec_out), 32'hBC);
    rd(2'd3, v); check("R9 set wins over clear", 32'(v), 32'h04);

    for (int c = 0; c < 4000; c++) begin
      src_req   = NSRC'($urandom);
      iack      = ($urandom % 4) == 0;
      bus_wr    = ($urandom % 3) == 0;
      bus_addr  = 2'($urandom);
      bus_wdata = 24'($urandom);
      tick();
    end
    iack = 1'b0; bus_wr = 1'b0;
    idle(2);

    done = 1;
    summary();
    $finish;
  end
endmodule